// File: doc/BRIEF.md
# Cascadable Serial Converter Front End

This block is the digital input stage of a 16-bit serial-fed converter. Code words arrive one bit per clock on a serial line, most significant bit first, and enter a shift register. A separate holding register drives the converter code. Because the two registers are separate, a new word can be shifted in while the converter keeps the previous code. Each register has its own active-low enable, and both act on the same rising clock edge. With this double buffer, several devices can be updated at once.

The code is binary two's complement: 0x7FFF is plus full scale, 0x8000 is minus full scale and 0x0000 is bipolar zero (midscale). An active-low clear empties both registers at once, with no clock edge needed. Clear is released only on clock edges. The last stage of the shift register is retimed on the falling edge and drives a serial output. Several devices can therefore be chained on one data stream, and N chained devices take 16N clocks to load.

Top module: `serdac_front`

## Requirements
- R1: When `shift_en_n` is low at a rising edge, the shift register moves up one place and `ser_in` enters bit 0. After 16 such edges, a word sent MSB first sits in the register in its original bit order.
- R2: When `shift_en_n` is high at a rising edge, the shift register keeps its contents, whatever `ser_in` does.
- R3: When `load_en_n` is low at a rising edge, `dac_code` takes the shift register contents as they stood before that edge.
- R4: When `load_en_n` is high at a rising edge, `dac_code` keeps its value.
- R5: When both enables are low on the same edge, `dac_code` takes the contents from before the shift, and the shift register still shifts.
- R6: While `clear_n` is low, `dac_code`, the shift register and `ser_out` are 0x0000 (midscale). They take this value as soon as `clear_n` falls, without a clock edge, and clear wins over both enables.
- R7: After `clear_n` (or `rst`) returns to its inactive level, the first two rising edges still hold everything at zero and ignore both enables. Normal operation starts on the third edge.
- R8: `ser_out` equals bit 15 of the shift register and changes only on the falling clock edge. At each rising edge it presents the MSB as it stood before that edge.
- R9: When the `ser_out` of one device drives the `ser_in` of a second device, the pair behaves as a 32-bit shift register. The first 16 bits sent end up in the far device.
- R10: `rst` high at a rising edge acts as a clear from that edge on, so all outputs read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and strobe clock |
| rst | input | 1 | Synchronous active-high reset, enters the clear state |
| ser_in | input | 1 | Serial data in, MSB first |
| shift_en_n | input | 1 | Active-low enable for the shift register |
| load_en_n | input | 1 | Active-low enable for the holding register |
| clear_n | input | 1 | Active-low clear, asserts asynchronously |
| dac_code | output | 16 | Held two's-complement converter code |
| ser_out | output | 1 | Serial output for chaining, falling-edge timed |

## Verification
The hardest cases to reach from the ports are the ones where several things happen on the same edge:
- both enables are low together;
- a clear is released while the enables are still active.

Random stimulus toggles each enable independently on every cycle, so both-low edges happen often. The bench also pulls `clear_n` low in the middle of a cycle now and then, keeps the enables active through the release, and checks that the two guard edges change nothing. Two chained instances let every step check the retimed serial output through the far device's shift register.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
    parameter int WORD_W     = 16;
    parameter int CLR_STAGES = 2;

    typedef struct packed {
        logic shift;
        logic load;
    } strobe_t;

    function automatic strobe_t decode_strobe(input logic shift_n, input logic load_n);
        strobe_t s;
        s.shift = ~shift_n;
        s.load  = ~load_n;
        return s;
    endfunction
endpackage

// File: rtl/serdac_clr_ctrl.sv
module serdac_clr_ctrl #(
    parameter int STAGES = serdac_pkg::CLR_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_n,
    output logic clr_act
);
    logic [STAGES-1:0] hold_q;

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)
            hold_q <= '1;
        else if (rst)
            hold_q <= '1;
        else
            hold_q <= {hold_q[STAGES-2:0], 1'b0};
    end

    assign clr_act = hold_q[STAGES-1];

    a_r6_clear_asserts: assert property (@(posedge clk) !clear_n |-> clr_act);
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
    parameter int W = serdac_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            q <= '0;
        else if (en)
            q <= {q[W-2:0], din};
    end

    a_r1_shift_up: assert property (@(posedge clk) disable iff (clr)
        en |=> (q == {$past(q[W-2:0]), $past(din)}));
    a_r2_shift_hold: assert property (@(posedge clk) disable iff (clr)
        !en |=> $stable(q));
endmodule

// File: rtl/serdac_hold.sv
module serdac_hold #(
    parameter int W = serdac_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            q <= '0;
        else if (load)
            q <= d;
    end

    a_r3_load_pre_edge: assert property (@(posedge clk) disable iff (clr)
        load |=> (q == $past(d)));
    a_r4_code_holds: assert property (@(posedge clk) disable iff (clr)
        !load |=> $stable(q));
endmodule

// File: rtl/serdac_sdo.sv
module serdac_sdo (
    input  logic clk,
    input  logic clr,
    input  logic msb,
    output logic so
);
    always_ff @(negedge clk or posedge clr) begin
        if (clr)
            so <= 1'b0;
        else
            so <= msb;
    end

    a_r8_sdo_tracks_msb: assert property (@(posedge clk) disable iff (clr) so == msb);
endmodule

// File: rtl/serdac_front.sv
module serdac_front
    import serdac_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int STAGES = CLR_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_in,
    input  logic         shift_en_n,
    input  logic         load_en_n,
    input  logic         clear_n,
    output logic [W-1:0] dac_code,
    output logic         ser_out
);
    strobe_t      strb;
    logic         clr_act;
    logic [W-1:0] shreg;

    assign strb = decode_strobe(shift_en_n, load_en_n);

    serdac_clr_ctrl #(.STAGES(STAGES)) u_clr (
        .clk     (clk),
        .rst     (rst),
        .clear_n (clear_n),
        .clr_act (clr_act)
    );

    serdac_shifter #(.W(W)) u_shift (
        .clk (clk),
        .clr (clr_act),
        .en  (strb.shift),
        .din (ser_in),
        .q   (shreg)
    );

    serdac_hold #(.W(W)) u_hold (
        .clk  (clk),
        .clr  (clr_act),
        .load (strb.load),
        .d    (shreg),
        .q    (dac_code)
    );

    serdac_sdo u_sdo (
        .clk (clk),
        .clr (clr_act),
        .msb (shreg[W-1]),
        .so  (ser_out)
    );

    a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        !clear_n |-> (dac_code == '0 && ser_out == 1'b0));
    a_r5_both_strobes: assert property (@(posedge clk) disable iff (clr_act)
        (!shift_en_n && !load_en_n) |=> (dac_code == $past(shreg) && shreg[0] == $past(ser_in)));
    a_r10_reset_clears: assert property (@(posedge clk) $past(rst) |-> (dac_code == '0));
endmodule

// File: tb/tb_serdac_front.sv
`timescale 1ns/1ps
module tb_serdac_front;
    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_in = 1'b0;
    logic        shift_en_n = 1'b1;
    logic        load_en_n = 1'b1;
    logic        clear_n = 1'b1;
    logic [15:0] code_a, code_b;
    logic        so_a, so_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state of both devices.
    logic [15:0] ma = '0, mb = '0, ha = '0, hb = '0;
    int          guard = 0;
    logic        xa, xb;

    always #(CLK_NS/2) clk = ~clk;

    serdac_front dut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .shift_en_n(shift_en_n),
        .load_en_n(load_en_n), .clear_n(clear_n), .dac_code(code_a), .ser_out(so_a)
    );
    serdac_front dut_b (
        .clk(clk), .rst(rst), .ser_in(so_a), .shift_en_n(shift_en_n),
        .load_en_n(load_en_n), .clear_n(clear_n), .dac_code(code_b), .ser_out(so_b)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply inputs just after a rising edge, then advance one edge and compare.
    task automatic step(input logic d, input logic sh_n, input logic ld_n,
                        input logic cl_n, input logic rs);
        string tag;
        ser_in = d; shift_en_n = sh_n; load_en_n = ld_n; clear_n = cl_n; rst = rs;
        @(posedge clk); #1;
        xa = ma[15];
        xb = mb[15];
        if (rs || !cl_n) begin
            ma = '0; mb = '0; ha = '0; hb = '0; guard = 2;
            xa = 1'b0; xb = 1'b0;
            tag = rs ? "R10" : "R6";
        end else if (guard > 0) begin
            guard--;
            tag = "R7";
        end else begin
            if (!ld_n) begin ha = ma; hb = mb; end
            if (!sh_n) begin
                mb = {mb[14:0], xa};
                ma = {ma[14:0], d};
            end
            tag = (!ld_n && !sh_n) ? "R5" : (!ld_n ? "R3" : "R4");
        end
        chk(tag, code_a, ha);
        chk("R9", code_b, hb);
        chk("R8", {15'd0, so_a}, {15'd0, xa});
        chk("R8", {15'd0, so_b}, {15'd0, xb});
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) step(w[i], 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7719));
        @(posedge clk); #1;
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R10", code_a, 16'h0000);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);

        // R1: full-scale words, MSB first, then latch
        send_word(16'h7FFF);
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R1", code_a, 16'h7FFF);
        send_word(16'h8000);
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R1", code_a, 16'h8000);
        chk("R9", code_b, 16'h7FFF);

        // R2: shift disabled while data toggles
        send_word(16'hA5C3);
        for (int i = 0; i < 6; i++) step(i[0], 1'b1, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R2", code_a, 16'hA5C3);

        // R6: asynchronous clear mid-cycle, visible before any edge
        #1 clear_n = 1'b0;
        #1;
        chk("R6", code_a, 16'h0000);
        chk("R6", {15'd0, so_a}, 16'h0000);
        ma = '0; mb = '0; ha = '0; hb = '0; guard = 2;
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R7: release with both enables active, two guard edges then run
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R7", code_a, 16'h0001);

        // Random traffic with occasional clears and resets
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 299);
            step(1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) != 0),
                 1'(r != 0), 1'(r == 1));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule